// File: doc/BRIEF.md
# Serial Converter Frame Sequencer

This block drives a 14-bit sampling converter over a three-wire link: an active-low select (`cs_n`), a serial clock (`sclk`) and a data line coming back from the converter (`sdo`). After reset it sends one short wake-up frame and then one full frame. The full frame must return the marker word 16'h3FC0. Once the marker has been seen, it runs full sample-and-convert frames, one after another, for as long as results are taken. Each full frame shifts in a 16-bit word. The upper 14 bits go out on a valid/ready port. A result that equals the marker is flagged as bad, because it shows that the conversion was cut short.

The data returned in a frame belongs to the sample taken in the frame before it. The data of the checking frame is therefore never delivered. The first delivered result carries the sample taken during the checking frame, and it is tagged `res_first`. If the marker does not come back, the wake-up and checking pair is sent again. After `MAX_RETRY` further failures the block sets a sticky `fault`, holds the converter deselected and stays there until the next reset.

States and transitions:
- `ST_BOOT` leads to `ST_SETUP` after one cycle.
- `ST_SETUP` drops select and goes to `ST_CLK` after one half-period.
- `ST_CLK` toggles the serial clock and goes to `ST_CONV` on the frame's last falling edge.
- `ST_CONV` holds select high for `CONV_WAIT` clocks. It then moves on according to the frame kind:
  - after a wake-up frame it goes to `ST_SETUP` as a checking frame;
  - after a checking frame it goes to `ST_SETUP` as a normal frame if the marker was seen, to `ST_SETUP` for a new wake-up frame on a retry, or to `ST_FAULT` when the retries are used up;
  - after a normal frame it goes to `ST_OUT`.
- `ST_OUT` goes to `ST_SETUP` when `res_ready` is high.
- `ST_FAULT` is final.

Top module: `adc_frame_ctrl`

## Requirements
- R1: The first frame after reset holds `cs_n` low for exactly `RESET_EDGES` (1..8) falling edges of `sclk`, then raises it.
- R2: The second frame has `FRAME_EDGES` falling edges. Its word is accepted as a good wake-up only if bits 15..2 equal those of 16'h3FC0 (14'h0FF0). Its data is never delivered, so the first result delivered is the word returned by the following frame.
- R3: If that check fails, the wake-up and checking frames repeat. After 1+`MAX_RETRY` failed checks, `fault` rises and stays high, `cs_n` stays high and no result is delivered.
- R4: Every frame after the first has `FRAME_EDGES` falling edges. `sclk` is low whenever `cs_n` is high. The first rising edge of `sclk` comes at least `DIV_HALF` clocks after `cs_n` falls.
- R5: Data is sampled on falling `sclk` edges, MSB first, so it is taken on the edge opposite to the one on which the converter changes it. `res_data` equals bits 15..2 of the received word, and bits 1..0 have no effect.
- R6: Between the last falling edge of a frame and the next fall of `cs_n`, `cs_n` stays high for at least `CONV_WAIT` clocks.
- R7: `res_err` is 1 exactly when `res_data` equals 14'h0FF0.
- R8: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_data` and `res_err` hold steady and `cs_n` stays high. No new frame starts until the result is taken.
- R9: `res_first` is 1 on the first result after each successful wake-up, and 0 on every later result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | output | 1 | Converter select, active low |
| sclk | output | 1 | Serial clock, idles low |
| sdo | input | 1 | Serial data from the converter |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |
| res_data | output | 14 | Conversion result |
| res_err | output | 1 | Result is the cut-short marker |
| res_first | output | 1 | First result after wake-up |
| fault | output | 1 | Sticky wake-up failure |

## Verification
The checks assume that the consumer never withdraws a result on its own. `res_ready` only counts while `res_valid` is high. They also assume that the converter changes `sdo` only after a rising edge of `sclk` and keeps it steady until the next falling edge. The bench's converter model drives `sdo` only at rising `sclk` edges, and `res_ready` is changed only on falling clock edges. Reset is applied only while `cs_n` is high, so a frame is never cut in half.

// File: rtl/adc_fc_pkg.sv
package adc_fc_pkg;
    localparam int WORD_W = 16;
    localparam int DATA_W = 14;
    localparam int PAD_W  = WORD_W - DATA_W;
    localparam logic [WORD_W-1:0] MARK_WORD = 16'h3FC0;

    typedef enum logic [2:0] {
        ST_BOOT, ST_SETUP, ST_CLK, ST_CONV, ST_OUT, ST_FAULT
    } fc_state_e;

    typedef enum logic [1:0] {
        K_INIT, K_CHECK, K_NORMAL
    } fc_kind_e;
endpackage

// File: rtl/adc_fc_count.sv
module adc_fc_count #(
    parameter int unsigned LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/adc_fc_shift.sv
module adc_fc_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         cap,
    input  logic         din,
    output logic [W-1:0] word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            word <= '0;
        else if (clr)
            word <= '0;
        else if (cap)
            word <= {word[W-2:0], din};
    end
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
    import adc_fc_pkg::*;
#(
    parameter int unsigned DIV_HALF    = 2,
    parameter int unsigned RESET_EDGES = 4,
    parameter int unsigned FRAME_EDGES = 24,
    parameter int unsigned CONV_WAIT   = 16,
    parameter int unsigned MAX_RETRY   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              cs_n,
    output logic              sclk,
    input  logic              sdo,
    output logic              res_valid,
    input  logic              res_ready,
    output logic [DATA_W-1:0] res_data,
    output logic              res_err,
    output logic              res_first,
    output logic              fault
);
    localparam int unsigned EW = $clog2(FRAME_EDGES + 1);
    localparam int unsigned TW = $clog2(MAX_RETRY + 1) + 1;
    localparam logic [DATA_W-1:0] MARK_DATA = MARK_WORD[WORD_W-1:PAD_W];

    fc_state_e         state_q, state_d;
    fc_kind_e          kind_q, kind_d;
    logic [EW-1:0]     ecnt_q;
    logic [TW-1:0]     tries_q;
    logic              first_q, fault_q, cs_n_q, sclk_q;
    logic              div_run, div_tick, wait_run, wait_done;
    logic              fall, last_fall, mark_hit, check_fail;
    logic [EW-1:0]     target;
    logic [WORD_W-1:0] word;

    assign div_run  = (state_q == ST_SETUP) || (state_q == ST_CLK);
    assign wait_run = (state_q == ST_CONV);

    adc_fc_count #(.LIMIT(DIV_HALF)) u_half (
        .clk(clk), .rst_n(rst_n), .run(div_run), .tick(div_tick)
    );

    adc_fc_count #(.LIMIT(CONV_WAIT)) u_wait (
        .clk(clk), .rst_n(rst_n), .run(wait_run), .tick(wait_done)
    );

    assign fall      = (state_q == ST_CLK) && div_tick && sclk_q;
    assign target    = (kind_q == K_INIT) ? EW'(RESET_EDGES) : EW'(FRAME_EDGES);
    assign last_fall = fall && (ecnt_q == target - 1'b1);

    adc_fc_shift #(.W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .clr(state_q == ST_SETUP),
        .cap(fall && (ecnt_q < EW'(WORD_W))),
        .din(sdo), .word(word)
    );

    assign mark_hit   = (word[WORD_W-1:PAD_W] == MARK_DATA);
    assign check_fail = (state_q == ST_CONV) && wait_done && (kind_q == K_CHECK) && !mark_hit;

    always_comb begin
        state_d = state_q;
        kind_d  = kind_q;
        unique case (state_q)
            ST_BOOT:  state_d = ST_SETUP;
            ST_SETUP: if (div_tick) state_d = ST_CLK;
            ST_CLK:   if (last_fall) state_d = ST_CONV;
            ST_CONV: begin
                if (wait_done) begin
                    unique case (kind_q)
                        K_INIT: begin
                            kind_d  = K_CHECK;
                            state_d = ST_SETUP;
                        end
                        K_CHECK: begin
                            if (mark_hit) begin
                                kind_d  = K_NORMAL;
                                state_d = ST_SETUP;
                            end else if (tries_q == TW'(MAX_RETRY)) begin
                                state_d = ST_FAULT;
                            end else begin
                                kind_d  = K_INIT;
                                state_d = ST_SETUP;
                            end
                        end
                        default: state_d = ST_OUT;
                    endcase
                end
            end
            ST_OUT:   if (res_ready) state_d = ST_SETUP;
            ST_FAULT: state_d = ST_FAULT;
            default:  state_d = ST_BOOT;
        endcase
    end

    // state register and frame bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
            kind_q  <= K_INIT;
            ecnt_q  <= '0;
            tries_q <= '0;
            first_q <= 1'b0;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            if (state_q == ST_SETUP)
                ecnt_q <= '0;
            else if (fall)
                ecnt_q <= ecnt_q + 1'b1;
            if (check_fail && (state_d != ST_FAULT))
                tries_q <= tries_q + 1'b1;
            if ((kind_q == K_CHECK) && (kind_d == K_NORMAL))
                first_q <= 1'b1;
            else if ((state_q == ST_OUT) && res_ready)
                first_q <= 1'b0;
        end
    end

    // registered pin outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_q  <= 1'b1;
            sclk_q  <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            cs_n_q  <= !((state_d == ST_SETUP) || (state_d == ST_CLK));
            if ((state_q == ST_CLK) && (state_d == ST_CLK))
                sclk_q <= div_tick ? ~sclk_q : sclk_q;
            else
                sclk_q <= 1'b0;
            fault_q <= fault_q | (state_d == ST_FAULT);
        end
    end

    assign cs_n      = cs_n_q;
    assign sclk      = sclk_q;
    assign fault     = fault_q;
    assign res_valid = (state_q == ST_OUT);
    assign res_data  = word[WORD_W-1:PAD_W];
    assign res_err   = mark_hit;
    assign res_first = first_q;

    a_r4_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);
    a_r4_setup_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |=> !sclk);
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_err));
    a_r8_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> cs_n);
    a_r3_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault && cs_n && !res_valid);
    a_r1_short_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLK) && (kind_q == K_INIT) |-> ecnt_q < EW'(RESET_EDGES));
    a_r7_err_code: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_err == (res_data == MARK_DATA)));
endmodule

// File: tb/tb_adc_frame_ctrl.sv
module tb_adc_frame_ctrl;
    localparam int CLK_P       = 10;
    localparam int DIV_HALF    = 2;
    localparam int RESET_EDGES = 4;
    localparam int FRAME_EDGES = 24;
    localparam int CONV_WAIT   = 16;
    localparam int MAX_RETRY   = 2;
    localparam int NV          = 8;
    localparam logic [15:0] VEC [NV] = '{16'hFFFF, 16'h0003, 16'hA5A6, 16'h3FC0,
                                         16'h3FC3, 16'h0004, 16'h8000, 16'h5555};

    logic clk = 1'b0, rst_n = 1'b0, sdo = 1'b0, res_ready = 1'b0;
    logic cs_n, sclk, res_valid, res_err, res_first, fault;
    logic [13:0] res_data;

    int errors = 0, checks = 0;
    int k = 0, vi = 0, frame_n = 0, init_cnt = 0;
    int frame_log [16];
    bit bad_init = 1'b0, have_rise = 1'b0, done = 1'b0;
    logic [15:0] cur = 16'h0, nxt = 16'h0;
    time t_rise = 0, t_fall = 0;

    always #(CLK_P/2) clk = ~clk;

    adc_frame_ctrl #(.DIV_HALF(DIV_HALF), .RESET_EDGES(RESET_EDGES), .FRAME_EDGES(FRAME_EDGES),
                     .CONV_WAIT(CONV_WAIT), .MAX_RETRY(MAX_RETRY)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdo(sdo),
        .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
        .res_err(res_err), .res_first(res_first), .fault(fault));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // converter model: changes sdo on rising sclk, logs frames
    initial begin
        forever begin
            @(posedge sclk or negedge cs_n or posedge cs_n);
            if (cs_n === 1'b0 && sclk === 1'b1) begin
                if (k == 0)
                    chk(($time - t_fall) >= DIV_HALF*CLK_P, "R4 setup", int'(($time - t_fall)/CLK_P), DIV_HALF);
                sdo = (k < 16) ? cur[15-k] : 1'b0;
                k++;
            end else if (cs_n === 1'b0) begin
                t_fall = $time;
                if (have_rise)
                    chk(($time - t_rise) >= CONV_WAIT*CLK_P, "R6 gap", int'(($time - t_rise)/CLK_P), CONV_WAIT);
                k = 0;
            end else if (cs_n === 1'b1 && k > 0) begin
                if (frame_n < 16) frame_log[frame_n] = k;
                frame_n++;
                if (k <= 8) begin
                    init_cnt++;
                    nxt = bad_init ? 16'h1234 : 16'h3FC0;
                end else begin
                    nxt = VEC[vi % NV];
                    vi++;
                end
                cur = nxt;
                k = 0;
                t_rise = $time;
                have_rise = 1'b1;
            end
        end
    end

    initial begin
        #(CLK_P*100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
    end

    task automatic wait_valid(output bit ok);
        ok = 1'b0;
        for (int n = 0; n < 5000; n++) begin
            @(negedge clk);
            if (res_valid) begin ok = 1'b1; break; end
        end
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        have_rise = 1'b0;
        repeat (3) @(negedge clk);
        vi = 0; frame_n = 0; init_cnt = 0;
        rst_n = 1'b1;
    endtask

    initial begin
        bit ok;
        logic [13:0] d0;
        bit stall_bad;
        repeat (2) @(negedge clk);
        chk(cs_n === 1'b1 && sclk === 1'b0, "R4 reset idle", {cs_n, sclk}, 2'b10);
        chk(res_valid === 1'b0 && fault === 1'b0, "R8 reset outputs", {res_valid, fault}, 0);
        do_reset();

        // vector table walk
        for (int i = 0; i < NV; i++) begin
            wait_valid(ok);
            chk(ok, "R8 result arrives", ok, 1);
            chk(res_data === VEC[i][15:2], "R5 data", res_data, VEC[i][15:2]);
            chk(res_err === (VEC[i][15:2] == 14'h0FF0), "R7 err flag", res_err, VEC[i][15:2] == 14'h0FF0);
            chk(res_first === (i == 0), "R9 first tag", res_first, i == 0);
            if (i == 2) begin
                d0 = res_data;
                stall_bad = 1'b0;
                for (int n = 0; n < 40; n++) begin
                    @(negedge clk);
                    if (!res_valid || !cs_n || res_data !== d0) stall_bad = 1'b1;
                end
                chk(!stall_bad, "R8 stall hold", stall_bad, 0);
            end
            res_ready = 1'b1;
            @(negedge clk);
            res_ready = 1'b0;
        end
        chk(frame_log[0] == RESET_EDGES, "R1 wake-up edges", frame_log[0], RESET_EDGES);
        chk(frame_log[1] == FRAME_EDGES, "R2 check frame edges", frame_log[1], FRAME_EDGES);
        chk(frame_log[2] == FRAME_EDGES, "R4 normal frame edges", frame_log[2], FRAME_EDGES);

        // failed wake-up: retries then sticky fault
        wait_valid(ok);
        bad_init = 1'b1;
        do_reset();
        for (int n = 0; n < 8000 && !fault; n++) @(negedge clk);
        chk(fault === 1'b1, "R3 fault raised", fault, 1);
        stall_bad = 1'b0;
        for (int n = 0; n < 200; n++) begin
            @(negedge clk);
            if (!fault || !cs_n || res_valid) stall_bad = 1'b1;
        end
        chk(!stall_bad, "R3 fault sticky and idle", stall_bad, 0);
        chk(init_cnt == MAX_RETRY + 1, "R3 wake-up attempts", init_cnt, MAX_RETRY + 1);

        // recovery after reset
        bad_init = 1'b0;
        do_reset();
        chk(fault === 1'b0, "R3 fault cleared by reset", fault, 0);
        wait_valid(ok);
        chk(ok && res_data === VEC[0][15:2], "R2 first result after check", res_data, VEC[0][15:2]);
        chk(res_first === 1'b1, "R9 first after recovery", res_first, 1);
        summary();
    end
endmodule